// File: doc/BRIEF.md
# Product-Term Array with Mode-Dependent Input Routing

This block is the programmable AND plane of a 20-input-class logic device. It holds a configuration image of 2706 bits. That image covers 64 product-term rows of 40 columns each, one disable bit per row, per-output polarity and I/O-select bits, two global mode bits and a 64-bit identification word. Each row is the AND of the columns it connects. The 40 columns are 20 routed signals, each presented as a true and complement pair. All 64 terms are computed every cycle from the stored image and the live inputs. Groups of eight terms go to eight output macrocells, which sit outside this block.

A routing multiplexer fills the 20 column pairs. Twelve pairs always carry the dedicated inputs. The other eight are macrocell slots, and the global mode decides what each slot carries: register feedback, an I/O pin, one of the two dual-purpose pins (clock pin and enable pin), or a neighbouring I/O pin. The image is loaded one bit at a time through a write port that takes an address and a data bit. That port is locked while the device is running.

Top module: `pterm_router`

## Requirements
- R1: After reset every configuration bit is 0, so `mode_o` is 0 (registered), `sig_o`, `pol_o` and `ac1_o` are 0, and every term in `terms_o` is 1 (a row with no connections is an empty AND).
- R2: A write with `cfg_we`=1, `run_en`=0 and `cfg_addr`<=2705 stores `cfg_bit` at that address at the clock edge, and the output that shows that bit reflects it in the following cycle.
- R3: A write while `run_en`=1 changes no configuration bit.
- R4: A write to any address above 2705 changes no configuration bit.
- R5: Row r uses bits r*40 to r*40+39, with column c at bit r*40+c. Column 2p carries the true value of pair p and column 2p+1 carries its complement. A bit value of 1 connects the column, and the term is 1 exactly when every connected column is 1.
- R6: A row that connects both the true and the complement column of the same pair gives 0 for every value of that signal.
- R7: When the disable bit at address 2640+r is 1, term r is 0, whatever its row holds.
- R8: Address 2560+m drives `pol_o[m]` and address 2632+m drives `ac1_o[m]`. Address 2704 is the sync bit and 2705 is the mode bit. `mode_o` is 0 (registered) when sync=0, 1 (complex) when sync=1 and mode=1, and 2 (simple) when sync=1 and mode=0.
- R9: Address 2568+k drives `sig_o[63-k]`, so the first address holds the most significant bit of the top byte.
- R10: Pairs 0 to 11 carry `ded_in[0]` to `ded_in[11]` in every mode.
- R11: In registered mode, pair 12+m carries `fb_q[m]` when `ac1_o[m]`=0 and `io_pin[m]` when `ac1_o[m]`=1. `clk_pin` and `oe_pin` reach no term.
- R12: In complex mode, pair 12 carries `clk_pin`, pair 19 carries `oe_pin`, and pairs 13 to 18 carry `io_pin[1]` to `io_pin[6]`. `io_pin[0]` and `io_pin[7]` reach no term.
- R13: In simple mode, pair 12 carries `clk_pin` and pair 19 carries `oe_pin`. Pairs 13 to 15 carry `io_pin[0]` to `io_pin[2]`, and pairs 16 to 18 carry `io_pin[5]` to `io_pin[7]`. `io_pin[3]` and `io_pin[4]` reach no term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration bit address |
| cfg_bit | input | 1 | Configuration data bit |
| run_en | input | 1 | Run state; blocks configuration writes while high |
| ded_in | input | 12 | Dedicated inputs |
| clk_pin | input | 1 | Dual-purpose pin, clock in registered mode |
| oe_pin | input | 1 | Dual-purpose pin, output enable in registered mode |
| fb_q | input | 8 | Register feedback from the macrocells |
| io_pin | input | 8 | Levels on the macrocell I/O pins |
| terms_o | output | 64 | Product terms, eight per macrocell |
| pol_o | output | 8 | Per-macrocell polarity bits |
| ac1_o | output | 8 | Per-macrocell I/O-select bits |
| sig_o | output | 64 | Identification word |
| mode_o | output | 2 | Decoded global mode |

## Verification
Two things can land in the same cycle: a configuration write that changes a routing bit, a row bit or a mode bit, and a change on the pins that the affected terms read. In the randomized phases the bench changes every input pin on every cycle. On about a quarter of those cycles it also writes a random bit into the macrocell-slot columns or into the I/O-select bits. Some of those writes are made with `run_en` high, so a locked write also meets live input traffic. After every edge the terms are compared with a model that applies the write and then evaluates the rows against the new pin values. A routing change and a pin change in the same cycle are therefore judged together, with neither one masking the other.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int N_TERMS   = 64;
  localparam int N_COLS    = 40;
  localparam int N_PAIRS   = N_COLS / 2;
  localparam int N_MACRO   = 8;
  localparam int N_DED     = N_PAIRS - N_MACRO;
  localparam int SIG_BITS  = 64;
  localparam int ADDR_W    = 12;

  localparam int ARR_FUSES = N_TERMS * N_COLS;
  localparam int POL_BASE  = ARR_FUSES;
  localparam int SIG_BASE  = POL_BASE + N_MACRO;
  localparam int AC1_BASE  = SIG_BASE + SIG_BITS;
  localparam int PTD_BASE  = AC1_BASE + N_MACRO;
  localparam int SYN_ADDR  = PTD_BASE + N_TERMS;
  localparam int AC0_ADDR  = SYN_ADDR + 1;
  localparam int LAST_ADDR = AC0_ADDR;
  localparam int FUSE_CNT  = LAST_ADDR + 1;

  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_CPLX = 2'd1,
    MODE_SMPL = 2'd2
  } mode_e;
endpackage

// File: rtl/ptr_fuse_store.sv
module ptr_fuse_store
  import ptr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wbit,
  input  logic                        run_en,
  output logic [ARR_FUSES-1:0]        arr,
  output logic [N_TERMS-1:0]          ptd,
  output logic [N_MACRO-1:0]          pol,
  output logic [N_MACRO-1:0]          ac1,
  output logic [SIG_BITS-1:0]         sig,
  output mode_e                       mode
);
  logic [FUSE_CNT-1:0] mem_q;
  logic [FUSE_CNT-1:0] mem_d;
  logic                wr_ok;
  logic                syn_b;
  logic                ac0_b;

  // accept only unlocked, in-range writes
  always_comb begin
    wr_ok = we & ~run_en & (addr <= ADDR_W'(LAST_ADDR));
    mem_d = mem_q;
    if (wr_ok) mem_d[addr] = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= '0;
    else if (wr_ok) mem_q <= mem_d;
  end

  assign arr   = mem_q[ARR_FUSES-1:0];
  assign ptd   = mem_q[PTD_BASE +: N_TERMS];
  assign pol   = mem_q[POL_BASE +: N_MACRO];
  assign ac1   = mem_q[AC1_BASE +: N_MACRO];
  assign syn_b = mem_q[SYN_ADDR];
  assign ac0_b = mem_q[AC0_ADDR];

  // identification word: lowest address is the most significant bit
  for (genvar k = 0; k < SIG_BITS; k++) begin : g_sig
    assign sig[SIG_BITS-1-k] = mem_q[SIG_BASE+k];
  end

  always_comb begin
    if (!syn_b)     mode = MODE_REG;
    else if (ac0_b) mode = MODE_CPLX;
    else            mode = MODE_SMPL;
  end
endmodule

// File: rtl/ptr_route.sv
module ptr_route
  import ptr_pkg::*;
(
  input  mode_e               mode,
  input  logic [N_MACRO-1:0]  ac1,
  input  logic [N_DED-1:0]    ded_in,
  input  logic                clk_pin,
  input  logic                oe_pin,
  input  logic [N_MACRO-1:0]  fb_q,
  input  logic [N_MACRO-1:0]  io_pin,
  output logic [N_PAIRS-1:0]  pair_v
);
  localparam int HALF = N_MACRO / 2;

  assign pair_v[N_DED-1:0] = ded_in;

  for (genvar m = 0; m < N_MACRO; m++) begin : g_slot
    logic reg_src;
    assign reg_src = ac1[m] ? io_pin[m] : fb_q[m];

    if (m == 0) begin : g_first
      always_comb begin
        if (mode == MODE_REG) pair_v[N_DED+m] = reg_src;
        else                  pair_v[N_DED+m] = clk_pin;
      end
    end else if (m == N_MACRO-1) begin : g_last
      always_comb begin
        if (mode == MODE_REG) pair_v[N_DED+m] = reg_src;
        else                  pair_v[N_DED+m] = oe_pin;
      end
    end else begin : g_mid
      // simple mode: slot takes the neighbouring pin one step further out
      localparam int NB = (m < HALF) ? m - 1 : m + 1;
      always_comb begin
        unique case (mode)
          MODE_REG:  pair_v[N_DED+m] = reg_src;
          MODE_CPLX: pair_v[N_DED+m] = io_pin[m];
          default:   pair_v[N_DED+m] = io_pin[NB];
        endcase
      end
    end
  end
endmodule

// File: rtl/ptr_terms.sv
module ptr_terms
  import ptr_pkg::*;
(
  input  logic [ARR_FUSES-1:0] arr,
  input  logic [N_TERMS-1:0]   ptd,
  input  logic [N_PAIRS-1:0]   pair_v,
  output logic [N_TERMS-1:0]   terms
);
  logic [N_COLS-1:0] col_v;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_col
    assign col_v[2*p]   = pair_v[p];
    assign col_v[2*p+1] = ~pair_v[p];
  end

  for (genvar r = 0; r < N_TERMS; r++) begin : g_row
    logic [N_COLS-1:0] row_f;
    assign row_f    = arr[r*N_COLS +: N_COLS];
    assign terms[r] = ~ptd[r] & (&(~row_f | col_v));
  end
endmodule

// File: rtl/pterm_router.sv
module pterm_router
  import ptr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 cfg_bit,
  input  logic                 run_en,
  input  logic [N_DED-1:0]     ded_in,
  input  logic                 clk_pin,
  input  logic                 oe_pin,
  input  logic [N_MACRO-1:0]   fb_q,
  input  logic [N_MACRO-1:0]   io_pin,
  output logic [N_TERMS-1:0]   terms_o,
  output logic [N_MACRO-1:0]   pol_o,
  output logic [N_MACRO-1:0]   ac1_o,
  output logic [SIG_BITS-1:0]  sig_o,
  output logic [1:0]           mode_o
);
  logic                 rst_meta_q;
  logic                 rst_sync_q;
  logic [ARR_FUSES-1:0] arr;
  logic [N_TERMS-1:0]   term_dis;
  logic [N_PAIRS-1:0]   pair_v;
  mode_e                mode;

  // reset asserts at once, releases on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ptr_fuse_store u_store (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wbit   (cfg_bit),
    .run_en (run_en),
    .arr    (arr),
    .ptd    (term_dis),
    .pol    (pol_o),
    .ac1    (ac1_o),
    .sig    (sig_o),
    .mode   (mode)
  );

  ptr_route u_route (
    .mode    (mode),
    .ac1     (ac1_o),
    .ded_in  (ded_in),
    .clk_pin (clk_pin),
    .oe_pin  (oe_pin),
    .fb_q    (fb_q),
    .io_pin  (io_pin),
    .pair_v  (pair_v)
  );

  ptr_terms u_terms (
    .arr    (arr),
    .ptd    (term_dis),
    .pair_v (pair_v),
    .terms  (terms_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/ptr_chk.sv
module ptr_chk
  import ptr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                we,
  input logic [ADDR_W-1:0]   addr,
  input logic                wbit,
  input logic                run_en,
  input logic [N_TERMS-1:0]  terms,
  input logic [N_TERMS-1:0]  term_dis,
  input logic [N_MACRO-1:0]  pol,
  input logic [N_MACRO-1:0]  ac1,
  input logic [SIG_BITS-1:0] sig,
  input logic [1:0]          mode
);
  logic [SIG_BITS-1:0] sig_hot;
  logic                sig_wr;

  always_comb begin
    sig_hot = '0;
    sig_wr  = we && !run_en && (addr >= ADDR_W'(SIG_BASE)) &&
              (addr < ADDR_W'(SIG_BASE + SIG_BITS));
    for (int k = 0; k < SIG_BITS; k++)
      if (sig_wr && (addr == ADDR_W'(SIG_BASE + k))) sig_hot[SIG_BITS-1-k] = 1'b1;
  end

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(sig) && $stable(pol) && $stable(ac1) && $stable(mode)));

  // R4
  range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > ADDR_W'(LAST_ADDR)) |=>
      ($stable(sig) && $stable(pol) && $stable(ac1) && $stable(mode)));

  // R7
  term_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((terms & term_dis) == '0));

  // R9
  sig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_wr |=> ((sig & $past(sig_hot)) == ($past(wbit) ? $past(sig_hot) : '0)));

  // R8
  sync_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !run_en && addr == ADDR_W'(SYN_ADDR)) |=> ((mode == 2'd0) == !$past(wbit)));
endmodule

bind pterm_router ptr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_q),
  .we       (cfg_we),
  .addr     (cfg_addr),
  .wbit     (cfg_bit),
  .run_en   (run_en),
  .terms    (terms_o),
  .term_dis (term_dis),
  .pol      (pol_o),
  .ac1      (ac1_o),
  .sig      (sig_o),
  .mode     (mode_o)
);

// File: tb/test_pterm_router.sv
module test_pterm_router;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic        cfg_bit;
  logic        run_en;
  logic [11:0] ded_in;
  logic        clk_pin;
  logic        oe_pin;
  logic [7:0]  fb_q;
  logic [7:0]  io_pin;
  logic [63:0] terms_o;
  logic [7:0]  pol_o;
  logic [7:0]  ac1_o;
  logic [63:0] sig_o;
  logic [1:0]  mode_o;

  int    checks = 0;
  int    errors = 0;
  bit    cmp_en = 0;
  bit    done   = 0;
  string cur_req = "R5";
  bit    mf [0:2705];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pterm_router i_pterm_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_bit(cfg_bit), .run_en(run_en), .ded_in(ded_in), .clk_pin(clk_pin),
    .oe_pin(oe_pin), .fb_q(fb_q), .io_pin(io_pin), .terms_o(terms_o),
    .pol_o(pol_o), .ac1_o(ac1_o), .sig_o(sig_o), .mode_o(mode_o)
  );

  // ---------------- reference model ----------------
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2706; i++) mf[i] = 1'b0;
    end else if (cfg_we && !run_en && cfg_addr <= 12'd2705) begin
      mf[cfg_addr] = cfg_bit;
    end
  end

  function automatic logic pair_val(int p);
    int m;
    if (p < 12) return ded_in[p];
    m = p - 12;
    if (!mf[2704]) return mf[2632+m] ? io_pin[m] : fb_q[m];
    if (m == 0) return clk_pin;
    if (m == 7) return oe_pin;
    if (mf[2705]) return io_pin[m];
    if (m < 4) return io_pin[m-1];
    return io_pin[m+1];
  endfunction

  function automatic logic [63:0] exp_terms();
    logic [63:0] t;
    for (int r = 0; r < 64; r++) begin
      t[r] = 1'b1;
      if (mf[2640+r]) t[r] = 1'b0;
      for (int c = 0; c < 40; c++) begin
        logic v;
        v = (c % 2 == 0) ? pair_val(c/2) : ~pair_val(c/2);
        if (mf[r*40+c] && !v) t[r] = 1'b0;
      end
    end
    return t;
  endfunction

  function automatic logic [63:0] exp_sig();
    logic [63:0] s;
    for (int k = 0; k < 64; k++) s[63-k] = mf[2568+k];
    return s;
  endfunction

  function automatic logic [7:0] exp_oct(int base);
    logic [7:0] v;
    for (int m = 0; m < 8; m++) v[m] = mf[base+m];
    return v;
  endfunction

  function automatic logic [1:0] exp_mode();
    if (!mf[2704]) return 2'd0;
    if (mf[2705]) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(terms_o === exp_terms(), cur_req, terms_o, exp_terms());
      chk(pol_o === exp_oct(2560), "R8", {56'd0, pol_o}, {56'd0, exp_oct(2560)});
      chk(ac1_o === exp_oct(2632), "R8", {56'd0, ac1_o}, {56'd0, exp_oct(2632)});
      chk(mode_o === exp_mode(), "R8", {62'd0, mode_o}, {62'd0, exp_mode()});
      chk(sig_o === exp_sig(), "R9", sig_o, exp_sig());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input bit b, input bit locked = 1'b0);
    step();
    cfg_we = 1'b1; cfg_addr = 12'(a); cfg_bit = b; run_en = locked;
    step();
    cfg_we = 1'b0; run_en = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic rand_phase(input string req, input int n);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      step();
      ded_in  = 12'($urandom);
      fb_q    = 8'($urandom);
      io_pin  = 8'($urandom);
      clk_pin = 1'($urandom);
      oe_pin  = 1'($urandom);
      if ($urandom % 4 == 0) begin
        cfg_we  = 1'b1;
        run_en  = ($urandom % 5 == 0);
        cfg_bit = 1'($urandom);
        if ($urandom % 3 == 0) cfg_addr = 12'(2632 + $urandom % 8);
        else cfg_addr = 12'((8 + $urandom % 8) * 40 + 24 + $urandom % 16);
      end else begin
        cfg_we = 1'b0; run_en = 1'b0;
      end
    end
    step();
    cfg_we = 1'b0; run_en = 1'b0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [63:0] t_snap, s_snap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_bit = 1'b0; run_en = 1'b0;
    ded_in = '0; clk_pin = 1'b0; oe_pin = 1'b0; fb_q = '0; io_pin = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();
    cmp_en = 1'b1;

    // R1 reset state
    sample();
    chk(terms_o === 64'hFFFF_FFFF_FFFF_FFFF, "R1", terms_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(mode_o === 2'd0 && sig_o === 64'd0, "R1", {sig_o[61:0], mode_o}, 64'd0);

    // R2 write then read back on signature
    wr(2568, 1'b1);
    sample();
    chk(sig_o[63] === 1'b1, "R2", {63'd0, sig_o[63]}, 64'd1);

    // R9 bit ordering at the far end
    wr(2631, 1'b1);
    sample();
    chk(sig_o === 64'h8000_0000_0000_0001, "R9", sig_o, 64'h8000_0000_0000_0001);

    // R3 locked write ignored
    wr(2568, 1'b0, 1'b1);
    sample();
    chk(sig_o[63] === 1'b1, "R3", {63'd0, sig_o[63]}, 64'd1);

    // R4 out-of-range writes ignored
    t_snap = terms_o; s_snap = sig_o;
    wr(2706, 1'b1);
    wr(4095, 1'b1);
    sample();
    chk(sig_o === s_snap && terms_o === t_snap && mode_o === 2'd0 &&
        pol_o === 8'd0 && ac1_o === 8'd0, "R4", terms_o, t_snap);

    // R10 and R5: row 0 takes the true column of ded_in[0]
    wr(0, 1'b1);
    step(); ded_in[0] = 1'b1; sample();
    chk(terms_o[0] === 1'b1, "R10", {63'd0, terms_o[0]}, 64'd1);
    step(); ded_in[0] = 1'b0; sample();
    chk(terms_o[0] === 1'b0, "R10", {63'd0, terms_o[0]}, 64'd0);

    // R5: row 1 = !ded1 & ded2
    wr(40 + 3, 1'b1);
    wr(40 + 4, 1'b1);
    step(); ded_in[1] = 1'b0; ded_in[2] = 1'b1; sample();
    chk(terms_o[1] === 1'b1, "R5", {63'd0, terms_o[1]}, 64'd1);
    step(); ded_in[1] = 1'b1; sample();
    chk(terms_o[1] === 1'b0, "R5", {63'd0, terms_o[1]}, 64'd0);

    // R6: row 2 connects both polarities of ded3
    wr(80 + 6, 1'b1);
    wr(80 + 7, 1'b1);
    step(); ded_in[3] = 1'b0; sample();
    chk(terms_o[2] === 1'b0, "R6", {63'd0, terms_o[2]}, 64'd0);
    step(); ded_in[3] = 1'b1; sample();
    chk(terms_o[2] === 1'b0, "R6", {63'd0, terms_o[2]}, 64'd0);

    // R7: row 3 is empty (1) until disabled
    sample();
    chk(terms_o[3] === 1'b1, "R7", {63'd0, terms_o[3]}, 64'd1);
    wr(2640 + 3, 1'b1);
    sample();
    chk(terms_o[3] === 1'b0, "R7", {63'd0, terms_o[3]}, 64'd0);

    // R8 arch bits and mode decode
    wr(2562, 1'b1);
    wr(2637, 1'b1);
    sample();
    chk(pol_o === 8'h04 && ac1_o === 8'h20, "R8", {48'd0, pol_o, ac1_o}, 64'h0420);
    wr(2704, 1'b1);
    wr(2705, 1'b1);
    sample();
    chk(mode_o === 2'd1, "R8", {62'd0, mode_o}, 64'd1);
    wr(2705, 1'b0);
    sample();
    chk(mode_o === 2'd2, "R8", {62'd0, mode_o}, 64'd2);
    wr(2704, 1'b0);
    wr(2637, 1'b0);

    // R11 registered mode: row 8 reads pair 12 true
    cur_req = "R11";
    wr(8*40 + 24, 1'b1);
    step(); fb_q[0] = 1'b1; io_pin[0] = 1'b0; sample();
    chk(terms_o[8] === 1'b1, "R11", {63'd0, terms_o[8]}, 64'd1);
    step(); clk_pin = 1'b1; oe_pin = 1'b1; fb_q[0] = 1'b0; sample();
    chk(terms_o[8] === 1'b0, "R11", {63'd0, terms_o[8]}, 64'd0);
    wr(2632, 1'b1);
    step(); io_pin[0] = 1'b1; sample();
    chk(terms_o[8] === 1'b1, "R11", {63'd0, terms_o[8]}, 64'd1);

    // R12 complex mode
    cur_req = "R12";
    wr(2704, 1'b1);
    wr(2705, 1'b1);
    wr(9*40 + 38, 1'b1);
    wr(10*40 + 26, 1'b1);
    step(); clk_pin = 1'b0; oe_pin = 1'b1; io_pin = 8'h02; sample();
    chk(terms_o[10:8] === 3'b110, "R12", {61'd0, terms_o[10:8]}, 64'd6);
    step(); io_pin = 8'h81; clk_pin = 1'b1; sample();
    chk(terms_o[10:8] === 3'b011, "R12", {61'd0, terms_o[10:8]}, 64'd3);

    // R13 simple mode
    cur_req = "R13";
    wr(2705, 1'b0);
    wr(11*40 + 32, 1'b1);
    step(); io_pin = 8'h21; sample();
    chk(terms_o[11:10] === 2'b11, "R13", {62'd0, terms_o[11:10]}, 64'd3);
    t_snap = terms_o;
    step(); io_pin = 8'h39; sample();
    chk(terms_o === t_snap, "R13", terms_o, t_snap);

    // mixed random traffic per mode
    wr(2704, 1'b0);
    rand_phase("R11", 400);
    wr(2704, 1'b1);
    wr(2705, 1'b1);
    rand_phase("R12", 400);
    wr(2705, 1'b0);
    rand_phase("R13", 400);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule